// File: doc/BRIEF.md
# DTMF Steering and Code Output Controller

This block sits behind a dual-tone classifier that reports, each clock, whether a legal row/column tone pair is present and which row and column it is. The controller replaces an external RC timing network with two programmable cycle counters. A pair must persist for a present guard time before its 4-bit code is captured. A captured tone must be absent for an absent guard time before the data-valid flag drops, so short gaps in the tone are bridged.

An early-steer flag follows the classifier's valid flag one cycle later. The 4-bit code register is updated first, and data-valid rises one cycle after that. The code stays in the register after the tone ends, until the next tone is accepted. A host reads the code over a 4-bit tristate bus that is gated by an output-enable input. A synchronous power-down input sends the controller back to idle.

Top module: `dtmf_steer_ctrl`

## Requirements
- R1: `early_steer` is a register of `pair_ok`. It is high in the cycle after any edge that samples `pair_ok` high, and low in the cycle after any edge that samples it low.
- R2: A tone is accepted only after P further consecutive edges sample the same pair present, counting from the edge that first samples it. P is `present_cycles`, and a value of 0 is treated as 1. The code register loads at that edge (P cycles after `early_steer` rises). A tone that is present for only P samples is rejected and leaves the code unchanged.
- R3: `data_valid` rises one clock after the code register loads. At that moment the code has therefore been stable for a full cycle.
- R4: If the row/column pair changes while a tone is still being qualified, the present guard restarts for the new pair.
- R5: After acceptance, the edge that first samples `pair_ok` low starts the absent guard. `data_valid` falls A cycles later, where A is `absent_cycles` and 0 is treated as 1. A gap of A samples or fewer does not change `data_valid`.
- R6: The code register keeps its value after `data_valid` falls, through rejected tones and through power-down, until the next accepted tone.
- R7: `row_idx` 0..3 selects the low-group tones from lowest to highest, and `col_idx` 0..3 does the same for the high group. Rows 0..2 in columns 0..2 encode as 3*row+col+1. Row 3 encodes as 1011 in column 0, 1010 in column 1 and 1100 in column 2. Column 3 encodes as 1101, 1110 and 1111 for rows 0..2, and as 0000 for row 3.
- R8: With `out_en` high, `code_bus` drives the code register. With `out_en` low, all four bits are released to high impedance, so an external pull sets their level. `early_steer` and `data_valid` are always driven.
- R9: An edge that samples `pwr_down` high forces idle, with `early_steer` and `data_valid` low in the following cycle. Qualification starts again once `pwr_down` is low.
- R10: While `data_valid` is high, a different pair is ignored. That pair can be accepted only through a fresh qualification after `data_valid` has returned low.
- R11: After reset, `early_steer` and `data_valid` are low and the code register holds 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Synchronous power-down, forces idle |
| pair_ok | input | 1 | Classifier reports a legal tone pair |
| row_idx | input | 2 | Low-group tone index, 0 is the lowest tone |
| col_idx | input | 2 | High-group tone index, 0 is the lowest tone |
| present_cycles | input | CNT_W | Present guard length in cycles |
| absent_cycles | input | CNT_W | Absent guard length in cycles |
| out_en | input | 1 | Drive enable for the code bus |
| early_steer | output | 1 | Registered tone-present flag |
| data_valid | output | 1 | Qualified tone flag |
| code_bus | output | 4 | Tristate code output |

## Verification
The bench sweeps all sixteen row/column pairs under several present and absent guard lengths. Each sweep step checks four things:
- the cycle in which the code loads;
- that `data_valid` rises one cycle after the code loads, and a design that raised it together with the code would fail here;
- the exact cycle of the `data_valid` fall;
- that the code is retained afterwards, and a design that cleared it would fail here.

Boundary runs cover tones one sample short of the present guard, gaps exactly equal to and one longer than the absent guard, a pair change during qualification, a new pair arriving while valid, a zero guard value, power-down, and the released bus seen through a pull-up. A design with an off-by-one counter, or one that overwrote the code while valid, would fail these runs.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    localparam int CODE_W = 4;
    localparam int IDX_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_LATCH,
        ST_VALID,
        ST_HOLD
    } steer_state_e;

    // Row/column pair to the 4-bit digit code (non-binary mapping).
    function automatic logic [CODE_W-1:0] pair_to_code(
        input logic [IDX_W-1:0] row,
        input logic [IDX_W-1:0] col
    );
        logic [CODE_W-1:0] r4;
        logic [CODE_W-1:0] c4;
        r4 = {2'b00, row};
        c4 = {2'b00, col};
        if (col == 2'd3) begin
            pair_to_code = (row == 2'd3) ? 4'b0000 : 4'd13 + r4;
        end else if (row != 2'd3) begin
            pair_to_code = (r4 << 1) + r4 + c4 + 4'd1;
        end else begin
            case (col)
                2'd0:    pair_to_code = 4'b1011;
                2'd1:    pair_to_code = 4'b1010;
                default: pair_to_code = 4'b1100;
            endcase
        end
    endfunction

endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map
    import dtmf_steer_pkg::*;
(
    input  logic [IDX_W-1:0]  row_idx,
    input  logic [IDX_W-1:0]  col_idx,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = pair_to_code(row_idx, col_idx);
    end
endmodule

// File: rtl/dtmf_guard_fsm.sv
module dtmf_guard_fsm
    import dtmf_steer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              pair_ok,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CNT_W-1:0]  present_cycles,
    input  logic [CNT_W-1:0]  absent_cycles,
    output logic              early_steer,
    output logic              data_valid,
    output logic              latch_stb,
    output logic [CODE_W-1:0] cand_code
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    steer_state_e      state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  p_lim;
    logic [CNT_W-1:0]  a_lim;
    logic [CODE_W-1:0] cand_q;
    logic              est_q;
    logic              same_pair;

    assign p_lim     = (present_cycles == '0) ? ONE : present_cycles;
    assign a_lim     = (absent_cycles  == '0) ? ONE : absent_cycles;
    assign same_pair = (code_in == cand_q);

    // Strobe fires on the edge that moves QUAL to LATCH.
    assign latch_stb = (state_q == ST_QUAL) && !pwr_down && pair_ok
                       && same_pair && (cnt_q >= p_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cand_q  <= '0;
            est_q   <= 1'b0;
        end else if (pwr_down) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            est_q   <= 1'b0;
        end else begin
            est_q <= pair_ok;
            unique case (state_q)
                ST_IDLE: begin
                    if (pair_ok) begin
                        cand_q  <= code_in;
                        cnt_q   <= ONE;
                        state_q <= ST_QUAL;
                    end
                end
                ST_QUAL: begin
                    if (!pair_ok) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else if (!same_pair) begin
                        cand_q <= code_in;
                        cnt_q  <= ONE;
                    end else if (cnt_q >= p_lim) begin
                        state_q <= ST_LATCH;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                ST_LATCH: begin
                    if (pair_ok) begin
                        state_q <= ST_VALID;
                    end else begin
                        state_q <= ST_HOLD;
                        cnt_q   <= ONE;
                    end
                end
                ST_VALID: begin
                    if (!pair_ok) begin
                        state_q <= ST_HOLD;
                        cnt_q   <= ONE;
                    end
                end
                ST_HOLD: begin
                    if (pair_ok) begin
                        state_q <= ST_VALID;
                    end else if (cnt_q >= a_lim) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign early_steer = est_q;
    assign data_valid  = (state_q == ST_VALID) || (state_q == ST_HOLD);
    assign cand_code   = cand_q;

endmodule

// File: rtl/dtmf_code_hold.sv
module dtmf_code_hold
    import dtmf_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              out_en,
    output logic [CODE_W-1:0] code_q,
    output wire  [CODE_W-1:0] code_bus
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= code_in;
        end
    end

    assign code_bus = out_en ? code_q : {CODE_W{1'bz}};
endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
    import dtmf_steer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic             pair_ok,
    input  logic [1:0]       row_idx,
    input  logic [1:0]       col_idx,
    input  logic [CNT_W-1:0] present_cycles,
    input  logic [CNT_W-1:0] absent_cycles,
    input  logic             out_en,
    output logic             early_steer,
    output logic             data_valid,
    output wire  [3:0]       code_bus
);
    logic [CODE_W-1:0] map_code;
    logic [CODE_W-1:0] cand_code;
    logic [CODE_W-1:0] code_q;
    logic              latch_stb;

    dtmf_code_map u_map (
        .row_idx (row_idx),
        .col_idx (col_idx),
        .code    (map_code)
    );

    dtmf_guard_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .pwr_down       (pwr_down),
        .pair_ok        (pair_ok),
        .code_in        (map_code),
        .present_cycles (present_cycles),
        .absent_cycles  (absent_cycles),
        .early_steer    (early_steer),
        .data_valid     (data_valid),
        .latch_stb      (latch_stb),
        .cand_code      (cand_code)
    );

    dtmf_code_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (latch_stb),
        .code_in  (cand_code),
        .out_en   (out_en),
        .code_q   (code_q),
        .code_bus (code_bus)
    );
endmodule

// File: rtl/dtmf_steer_checker.sv
module dtmf_steer_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_down,
    input logic       pair_ok,
    input logic       out_en,
    input logic       early_steer,
    input logic       data_valid,
    input logic [3:0] code_q,
    input logic [3:0] code_bus
);
    p_est_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (pair_ok && !pwr_down) |=> early_steer);

    p_est_fall_r1: assert property (@(posedge clk) disable iff (rst)
        !pair_ok |=> !early_steer);

    p_dv_after_steer_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(early_steer));

    p_code_stable_at_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $stable(code_q));

    p_dv_fall_absent_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(data_valid) |-> (!$past(pair_ok) || $past(pwr_down)));

    p_bus_drives_code_r8: assert property (@(posedge clk) disable iff (rst)
        out_en |-> (code_bus == code_q));

    p_pwr_down_idle_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!early_steer && !data_valid));

    p_code_frozen_valid_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> !data_valid);
endmodule

bind dtmf_steer_ctrl dtmf_steer_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_down    (pwr_down),
    .pair_ok     (pair_ok),
    .out_en      (out_en),
    .early_steer (early_steer),
    .data_valid  (data_valid),
    .code_q      (code_q),
    .code_bus    (code_bus)
);

// File: tb/dtmf_steer_ctrl_bench.sv
module dtmf_steer_ctrl_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwr_down = 1'b0;
    logic             pair_ok = 1'b0;
    logic [1:0]       row_idx = '0;
    logic [1:0]       col_idx = '0;
    logic [CNT_W-1:0] present_cycles = CNT_W'(1);
    logic [CNT_W-1:0] absent_cycles = CNT_W'(1);
    logic             out_en = 1'b1;
    logic             early_steer;
    logic             data_valid;
    wire  [3:0]       code_bus;

    pullup (code_bus[0]);
    pullup (code_bus[1]);
    pullup (code_bus[2]);
    pullup (code_bus[3]);

    int checks = 0;
    int failures = 0;
    logic [3:0] last_code = 4'b0000;

    always #10 clk = ~clk;

    dtmf_steer_ctrl #(.CNT_W(CNT_W)) u_dtmf_steer_ctrl (
        .clk            (clk),
        .rst            (rst),
        .pwr_down       (pwr_down),
        .pair_ok        (pair_ok),
        .row_idx        (row_idx),
        .col_idx        (col_idx),
        .present_cycles (present_cycles),
        .absent_cycles  (absent_cycles),
        .out_en         (out_en),
        .early_steer    (early_steer),
        .data_valid     (data_valid),
        .code_bus       (code_bus)
    );

    function automatic logic [3:0] exp_code(input int r, input int c);
        if (c == 3) return (r == 3) ? 4'd0 : 4'(13 + r);
        if (r < 3) return 4'(3 * r + c + 1);
        if (c == 0) return 4'd11;
        if (c == 1) return 4'd10;
        return 4'd12;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Apply a pair, check load and rise timing, hold, then release and check fall.
    task automatic run_digit(input int r, input int c, input int p, input int a);
        int pe;
        int ae;
        logic [3:0] e;
        pe = (p == 0) ? 1 : p;
        ae = (a == 0) ? 1 : a;
        e  = exp_code(r, c);
        row_idx = 2'(r);
        col_idx = 2'(c);
        present_cycles = CNT_W'(p);
        absent_cycles  = CNT_W'(a);
        pair_ok = 1'b1;
        for (int k = 1; k <= pe + 2; k++) begin
            step();
            if (k == 1) chk("R1", "steer rise", {3'b0, early_steer}, 4'd1);
            if (k == pe && last_code != e) chk("R2", "no early load", code_bus, last_code);
            if (k == pe + 1) begin
                chk("R7", "code value", code_bus, e);
                chk("R3", "valid low at load", {3'b0, data_valid}, 4'd0);
            end
            if (k == pe + 2) chk("R3", "valid rise", {3'b0, data_valid}, 4'd1);
        end
        last_code = e;
        step();
        pair_ok = 1'b0;
        for (int j = 1; j <= ae + 1; j++) begin
            step();
            if (j == 1) chk("R1", "steer fall", {3'b0, early_steer}, 4'd0);
            if (j == ae) chk("R5", "valid held in guard", {3'b0, data_valid}, 4'd1);
            if (j == ae + 1) begin
                chk("R5", "valid fall", {3'b0, data_valid}, 4'd0);
                chk("R6", "code kept", code_bus, e);
            end
        end
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R11", "steer after reset", {3'b0, early_steer}, 4'd0);
        chk("R11", "valid after reset", {3'b0, data_valid}, 4'd0);
        chk("R11", "code after reset", code_bus, 4'd0);

        // R7 sweep of all pairs with varied guards
        for (int idx = 0; idx < 16; idx++) begin
            run_digit(idx / 4, idx % 4, 1 + idx % 3, 1 + (idx / 3) % 3);
        end

        // R2 zero present guard behaves as one
        run_digit(0, 0, 0, 0);

        // R2 short tone rejected
        row_idx = 2'd2; col_idx = 2'd1;
        present_cycles = CNT_W'(4);
        absent_cycles  = CNT_W'(2);
        pair_ok = 1'b1;
        repeat (4) step();
        pair_ok = 1'b0;
        repeat (3) step();
        chk("R2", "short tone no valid", {3'b0, data_valid}, 4'd0);
        chk("R6", "short tone code kept", code_bus, last_code);

        // R4 pair change during qualification restarts guard
        row_idx = 2'd1; col_idx = 2'd1;
        present_cycles = CNT_W'(3);
        pair_ok = 1'b1;
        repeat (2) step();
        row_idx = 2'd2; col_idx = 2'd2;
        for (int m = 1; m <= 5; m++) begin
            step();
            if (m == 3) chk("R4", "restart no load", code_bus, last_code);
            if (m == 4) chk("R4", "restart load", code_bus, exp_code(2, 2));
            if (m == 4) chk("R4", "restart valid low", {3'b0, data_valid}, 4'd0);
            if (m == 5) chk("R4", "restart valid rise", {3'b0, data_valid}, 4'd1);
        end
        pair_ok = 1'b0;
        repeat (4) step();
        last_code = exp_code(2, 2);

        // R5 dropout of exactly the absent guard is bridged
        row_idx = 2'd3; col_idx = 2'd3;
        present_cycles = CNT_W'(2);
        absent_cycles  = CNT_W'(3);
        pair_ok = 1'b1;
        repeat (5) step();
        pair_ok = 1'b0;
        repeat (3) step();
        chk("R5", "gap equal guard", {3'b0, data_valid}, 4'd1);
        pair_ok = 1'b1;
        repeat (2) step();
        chk("R5", "valid after gap", {3'b0, data_valid}, 4'd1);
        pair_ok = 1'b0;
        repeat (4) step();
        chk("R5", "gap over guard", {3'b0, data_valid}, 4'd0);
        chk("R7", "row3 col3 code", code_bus, 4'd0);
        last_code = 4'd0;

        // R10 different pair while valid is ignored
        row_idx = 2'd1; col_idx = 2'd1;
        present_cycles = CNT_W'(1);
        absent_cycles  = CNT_W'(1);
        pair_ok = 1'b1;
        repeat (4) step();
        row_idx = 2'd2; col_idx = 2'd2;
        repeat (6) step();
        chk("R10", "code unchanged", code_bus, 4'd5);
        chk("R10", "valid still high", {3'b0, data_valid}, 4'd1);
        pair_ok = 1'b0;
        repeat (2) step();
        chk("R10", "valid low", {3'b0, data_valid}, 4'd0);
        last_code = 4'd5;
        run_digit(2, 2, 1, 1);

        // R8 bus release and R9 power-down
        row_idx = 2'd3; col_idx = 2'd3;
        pair_ok = 1'b1;
        repeat (4) step();
        out_en = 1'b0;
        #1;
        chk("R8", "bus released", code_bus, 4'b1111);
        chk("R8", "valid driven", {3'b0, data_valid}, 4'd1);
        out_en = 1'b1;
        #1;
        chk("R8", "bus driven", code_bus, 4'b0000);
        pwr_down = 1'b1;
        step();
        chk("R9", "steer low", {3'b0, early_steer}, 4'd0);
        chk("R9", "valid low", {3'b0, data_valid}, 4'd0);
        chk("R6", "code through power-down", code_bus, 4'b0000);
        pwr_down = 1'b0;
        step();
        chk("R9", "steer resumes", {3'b0, early_steer}, 4'd1);
        pair_ok = 1'b0;
        repeat (3) step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule